// File: doc/BRIEF.md
# Subroutine Call Stack Sequencer

This block carries out the two-word subroutine call of a small processor with byte-addressed memory and 16-bit registers. It holds the program counter, the stack pointer and the status word. When it accepts a call request, it first reads the word that follows the call opcode, which is the subroutine entry address. It then pushes the return address onto a memory stack, pushes the status word and loads the program counter with the entry address. The call opcode sits at the address held in the program counter.

The stack begins at a configurable base address and grows toward higher addresses. The stack pointer always names the top item that is present, so every push first advances the pointer by one word (2 bytes) and then writes at the new address. Memory is reached through one synchronous port: read data arrives in the cycle after the address is presented, and a write stores one whole 16-bit word at an even byte address, low byte at the lower address. A `busy` level covers the four working cycles. A one-cycle `done` pulse follows in the cycle after the program counter takes the entry address.

Top module: `subcall_seq`

## Requirements
- R1: After reset, sp_out is STACK_BASE-2 (0x00FE by default), pc_out is RESET_PC (0x0200), psw_out is 0, and busy, done and mem_we are low.
- R2: In the first busy cycle after a call is accepted, the port reads (mem_we low) at byte address pc_out+2.
- R3: In the second busy cycle, the port writes the return address, equal to the call's address plus 4, at the old sp_out+2.
- R4: In the third busy cycle, the port writes the status word at the old sp_out+4.
- R5: When done is high, sp_out equals its value before the call plus 4.
- R6: When done is high, pc_out equals the word read from address call address+2.
- R7: busy stays high for exactly four cycles. done is high for exactly one cycle, the first cycle after busy falls, and done is low again in the following cycle.
- R8: A call request presented while busy is ignored. No extra memory write occurs and sp_out still advances by only 4.
- R9: psw_set while idle loads psw_val into psw_out at the next edge. psw_set while busy leaves psw_out unchanged.
- R10: When psw_set and call_req arrive in the same idle cycle, both take effect, and the status word pushed by that call is the new value.
- R11: mem_we is low whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Request to execute the call at pc_out |
| psw_set | input | 1 | Load psw_val into the status word (idle only) |
| psw_val | input | 16 | New status word value |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| mem_addr | output | 16 | Byte address, always even |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write enable for one word |
| busy | output | 1 | Call sequence in progress |
| done | output | 1 | One-cycle pulse after the program counter is loaded |
| sp_out | output | 16 | Stack pointer |
| pc_out | output | 16 | Program counter |
| psw_out | output | 16 | Status word |

## Verification
A status-word update and a call acceptance can land on the same idle edge. The bench provokes this by raising psw_set and call_req together, then checks that the third-cycle write carries the new value and that psw_out keeps it afterwards. Separately, status updates and repeat call requests are injected in the middle of a sequence, and the bench checks that neither changes the pushed data, the stack pointer or the write count.

// File: rtl/subcall_pkg.sv
package subcall_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_PUSH_RET,
      ST_PUSH_PSW,
      ST_LOAD
   } seq_state_e;
endpackage

// File: rtl/subcall_ctrl.sv
module subcall_ctrl
   import subcall_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       call_req,
   output seq_state_e state,
   output logic       done
);
   seq_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:     if (call_req) state_nx = ST_FETCH;
         ST_FETCH:    state_nx = ST_PUSH_RET;
         ST_PUSH_RET: state_nx = ST_PUSH_PSW;
         ST_PUSH_PSW: state_nx = ST_LOAD;
         ST_LOAD:     state_nx = ST_IDLE;
         default:     state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= state_nx;
         done  <= (state == ST_LOAD);
      end
   end
endmodule

// File: rtl/subcall_regs.sv
module subcall_regs
   import subcall_pkg::*;
#(
   parameter int                WORD_W     = 16,
   parameter int                CALL_WORDS = 2,
   parameter logic [WORD_W-1:0] STACK_BASE = 16'h0100,
   parameter logic [WORD_W-1:0] RESET_PC   = 16'h0200,
   parameter logic [WORD_W-1:0] RESET_PSW  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_e        state,
   input  logic              psw_set,
   input  logic [WORD_W-1:0] psw_val,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic [WORD_W-1:0] sp,
   output logic [WORD_W-1:0] pc,
   output logic [WORD_W-1:0] psw
);
   localparam int                WORD_BYTES = WORD_W / 8;
   localparam logic [WORD_W-1:0] STEP       = WORD_W'(WORD_BYTES);
   localparam logic [WORD_W-1:0] RET_OFS    = WORD_W'(WORD_BYTES * CALL_WORDS);
   localparam logic [WORD_W-1:0] SP_EMPTY   = STACK_BASE - STEP;

   logic [WORD_W-1:0] tgt;
   logic [WORD_W-1:0] sp_next;

   assign sp_next = sp + STEP;

   always_comb begin
      mem_we    = 1'b0;
      mem_wdata = '0;
      mem_addr  = pc + STEP;
      unique case (state)
         ST_PUSH_RET: begin
            mem_we    = 1'b1;
            mem_addr  = sp_next;
            mem_wdata = pc + RET_OFS;
         end
         ST_PUSH_PSW: begin
            mem_we    = 1'b1;
            mem_addr  = sp_next;
            mem_wdata = psw;
         end
         default: mem_addr = pc + STEP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp  <= SP_EMPTY;
         pc  <= RESET_PC;
         psw <= RESET_PSW;
         tgt <= '0;
      end else begin
         if (state == ST_IDLE && psw_set) psw <= psw_val;
         unique case (state)
            ST_PUSH_RET: begin
               tgt <= mem_rdata;
               sp  <= sp_next;
            end
            ST_PUSH_PSW: sp <= sp_next;
            ST_LOAD:     pc <= tgt;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/subcall_seq.sv
module subcall_seq
   import subcall_pkg::*;
#(
   parameter int                WORD_W     = 16,
   parameter int                CALL_WORDS = 2,
   parameter logic [WORD_W-1:0] STACK_BASE = 16'h0100,
   parameter logic [WORD_W-1:0] RESET_PC   = 16'h0200,
   parameter logic [WORD_W-1:0] RESET_PSW  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_req,
   input  logic              psw_set,
   input  logic [WORD_W-1:0] psw_val,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] sp_out,
   output logic [WORD_W-1:0] pc_out,
   output logic [WORD_W-1:0] psw_out
);
   generate
      if (WORD_W % 8 != 0 || WORD_W < 8) begin : g_bad_width
         $error("subcall_seq: WORD_W must be a whole number of bytes");
      end
      if (CALL_WORDS < 2) begin : g_bad_len
         $error("subcall_seq: a call needs an opcode word and a target word");
      end
      if (STACK_BASE[0] != 1'b0 || RESET_PC[0] != 1'b0) begin : g_bad_align
         $error("subcall_seq: stack base and reset PC must be word aligned");
      end
   endgenerate

   seq_state_e state;

   subcall_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .call_req (call_req),
      .state    (state),
      .done     (done)
   );

   subcall_regs #(
      .WORD_W     (WORD_W),
      .CALL_WORDS (CALL_WORDS),
      .STACK_BASE (STACK_BASE),
      .RESET_PC   (RESET_PC),
      .RESET_PSW  (RESET_PSW)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state),
      .psw_set   (psw_set),
      .psw_val   (psw_val),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .sp        (sp_out),
      .pc        (pc_out),
      .psw       (psw_out)
   );

   assign busy = (state != ST_IDLE);
endmodule

// File: rtl/subcall_seq_chk.sv
module subcall_seq_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              call_req,
   input logic              psw_set,
   input logic [WORD_W-1:0] psw_val,
   input logic [WORD_W-1:0] mem_rdata,
   input logic [WORD_W-1:0] mem_addr,
   input logic [WORD_W-1:0] mem_wdata,
   input logic              mem_we,
   input logic              busy,
   input logic              done,
   input logic [WORD_W-1:0] sp_out,
   input logic [WORD_W-1:0] pc_out,
   input logic [WORD_W-1:0] psw_out
);
   localparam logic [WORD_W-1:0] TWO  = WORD_W'(2);
   localparam logic [WORD_W-1:0] FOUR = WORD_W'(4);

   p_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!mem_we && mem_addr == pc_out + TWO));

   p_push_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> (mem_we && mem_addr == $past(sp_out) + TWO
                       && mem_wdata == $past(pc_out) + FOUR));

   p_sp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> sp_out == $past(sp_out, 5) + FOUR);

   p_pc_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> pc_out == $past(mem_rdata, 3));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_psw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(psw_out));

   p_idle_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_we);
endmodule

bind subcall_seq subcall_seq_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/subcall_seq_bench.sv
`timescale 1ns/1ps
module subcall_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_req = 1'b0;
   logic        psw_set = 1'b0;
   logic [15:0] psw_val = '0;
   logic [15:0] mem_rdata;
   logic [15:0] mem_addr, mem_wdata, sp_out, pc_out, psw_out;
   logic        mem_we, busy, done;

   logic        tb_we = 1'b0;
   logic [15:0] tb_addr = '0;
   logic [15:0] tb_data = '0;
   logic [15:0] mem [512];

   int n_checks = 0;
   int n_errors = 0;

   always #4 clk = ~clk;

   subcall_seq u_subcall_seq (
      .clk(clk), .rst_n(rst_n), .call_req(call_req), .psw_set(psw_set),
      .psw_val(psw_val), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .done(done),
      .sp_out(sp_out), .pc_out(pc_out), .psw_out(psw_out)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[9:1]] <= mem_wdata;
      else if (tb_we) mem[tb_addr[9:1]] <= tb_data;
      mem_rdata <= mem[mem_addr[9:1]];
   end

   function automatic logic [15:0] ret_addr(input logic [15:0] pc);
      return pc + 16'd4;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   task automatic run_call(input int mode);
      logic [15:0] o_sp, o_pc, o_psw, tgt, npsw, exp_psw;
      o_sp = sp_out; o_pc = pc_out; o_psw = psw_out;
      tgt  = 16'h0200 + 16'(2 * ($urandom % 250));
      npsw = 16'($urandom);
      @(negedge clk);
      tb_we = 1'b1; tb_addr = o_pc + 16'd2; tb_data = tgt;
      @(negedge clk);
      tb_we = 1'b0;
      call_req = 1'b1;
      if (mode == 3) begin psw_set = 1'b1; psw_val = npsw; end
      exp_psw = (mode == 3) ? npsw : o_psw;
      @(negedge clk);
      call_req = (mode == 1);
      psw_set = 1'b0;
      chk("R2 busy", 16'(busy), 16'd1);
      chk("R2 read", 16'(mem_we), 16'd0);
      chk("R2 addr", mem_addr, o_pc + 16'd2);
      if (mode == 2) begin psw_set = 1'b1; psw_val = npsw; end
      @(negedge clk);
      psw_set = 1'b0;
      chk("R3 we", 16'(mem_we), 16'd1);
      chk("R3 addr", mem_addr, o_sp + 16'd2);
      chk("R3 data", mem_wdata, ret_addr(o_pc));
      @(negedge clk);
      chk("R4 we", 16'(mem_we), 16'd1);
      chk("R4 addr", mem_addr, o_sp + 16'd4);
      chk(mode == 3 ? "R10 pushed psw" : "R4 data", mem_wdata, exp_psw);
      @(negedge clk);
      call_req = 1'b0;
      chk("R7 busy 4th", 16'(busy), 16'd1);
      chk("R8 no write", 16'(mem_we), 16'd0);
      @(negedge clk);
      chk("R7 done", 16'(done), 16'd1);
      chk("R7 idle", 16'(busy), 16'd0);
      chk("R6 pc", pc_out, tgt);
      chk(mode == 1 ? "R8 sp" : "R5 sp", sp_out, o_sp + 16'd4);
      chk(mode == 2 ? "R9 psw busy" : "R10 psw", psw_out, exp_psw);
      chk("R11 idle we", 16'(mem_we), 16'd0);
      chk("R3 stored", mem[16'(o_sp + 16'd2) >> 1], ret_addr(o_pc));
      chk("R4 stored", mem[16'(o_sp + 16'd4) >> 1], exp_psw);
      @(negedge clk);
      chk("R7 pulse", 16'(done), 16'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      int unsigned seed;
      logic [15:0] v;
      seed = $urandom(32'd4242);
      for (int i = 0; i < 512; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 sp", sp_out, 16'h00FE);
      chk("R1 pc", pc_out, 16'h0200);
      chk("R1 psw", psw_out, 16'h0000);
      chk("R1 busy", 16'(busy), 16'd0);
      chk("R1 done", 16'(done), 16'd0);
      chk("R1 we", 16'(mem_we), 16'd0);
      // directed: one call of each mode
      for (int m = 0; m < 4; m++) run_call(m);
      // random mix
      for (int i = 0; i < 30; i++) begin
         if ($urandom % 2 == 1) begin
            v = 16'($urandom);
            psw_set = 1'b1; psw_val = v;
            @(negedge clk);
            psw_set = 1'b0;
            chk("R9 idle load", psw_out, v);
         end
         run_call(int'($urandom % 4));
      end
      finish_run();
   end
endmodule